// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Status

This block collects 72 level-sensitive interrupt lines into three groups: a small group of 8 lines (group 0) and two wide groups of 32 lines each (groups 1 and 2). Every group has its own mask, built up with a write-one-to-set port and torn down with a write-one-to-clear port. Every group also has a status word that shows which lines are high and unmasked. Nothing is latched: a status bit follows its input from cycle to cycle.

The group 0 status word is the one a handler reads first. Besides the 8 local lines it carries two summary flags, one for group 1 and one for group 2, and eleven shortcut flags. Each shortcut flag mirrors one chosen line of group 1 or group 2, so the handler can identify that line without a second read. A line with a shortcut never raises its group's summary flag. The normal interrupt output is the OR of the meaningful group 0 status bits.

A separate selector routes one of the 72 raw lines to a fast-interrupt output. The selector numbers the lines group 1 first, then group 2, then group 0. Software reaches all registers over a simple 32-bit bus with an address, a write strobe, write data and combinational read data.

Top module: `bank_intc`

## Requirements
- R1: After reset every mask is 0 and the fast-interrupt control word is 0. Mask and control reads return 0, every status word reads 0 and both outputs stay low, even while inputs are high.
- R2: A write to a set port (group 0 at 0x18, group 1 at 0x10, group 2 at 0x14) ORs the write data into that group's mask. A write to a clear port (group 0 at 0x24, group 1 at 0x1C, group 2 at 0x20) removes the set bits from the mask. Both the set and the clear offset read back the current mask. The update is visible from the cycle after the write.
- R3: The group 1 status word (0x04) and the group 2 status word (0x08) read input AND mask. A bit drops as soon as its input drops.
- R4: Group 0 status (0x00) bits 7:0 read the group 0 inputs AND the group 0 mask.
- R5: Group 0 status bit 8 is 1 when a group 1 line outside the shortcut list is high and unmasked. Bit 9 does the same for group 2. Software cannot mask these two bits directly.
- R6: Group 1 lines 7, 9, 10, 18 and 19 appear, in that order, on group 0 status bits 10 to 14. Group 2 lines 21, 22, 23, 24, 25 and 30 appear on bits 15 to 20. An unmasked shortcut line sets its shortcut bit and its own group status bit. It does not set the summary bit.
- R7: The group 0 mask holds only bits 7:0, and writes to higher bits of its set and clear ports have no effect. A shortcut line can therefore be masked only through its own group's ports.
- R8: The interrupt output is high exactly when some bit in 20:0 of the group 0 status word is 1.
- R9: The control word at 0x0C holds a line index in bits 6:0 and an enable in bit 7. Indices 0 to 31 select group 1, 32 to 63 select group 2, 64 to 71 select group 0, and 72 to 127 select nothing. Bits 31:8 read as 0. The fast-interrupt output is high when the enable is set and the selected raw input is high, whatever the masks hold.
- R10: A line chosen for the fast interrupt still feeds the normal path. When that line is also unmasked, both outputs are high together.
- R11: Reads of any other offset, including misaligned ones, return 0. Writes to the status offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| we | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| src_b0 | input | 8 | Group 0 interrupt lines |
| src_b1 | input | 32 | Group 1 interrupt lines |
| src_b2 | input | 32 | Group 2 interrupt lines |
| irq | output | 1 | Normal interrupt output |
| fiq | output | 1 | Fast interrupt output |

## Verification
The bench builds the block with its default widths of 8 and 32 lines per group and a 32-bit word. These are the only widths the fixed shortcut map fits. With them the whole 7-bit selector range is reachable: the edge indices of each group and the dead indices 72 to 127. Every shortcut position can be driven against its summary bit, including mixed patterns where a shortcut line and a plain line of the same group are high together.

// File: rtl/bank_intc_pkg.sv
package bank_intc_pkg;

  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int B0_SRC   = 8;
  localparam int BX_SRC   = 32;
  localparam int N_GROUPS = 3;
  localparam int SC1_N    = 5;
  localparam int SC2_N    = 6;

  localparam int SUM1_BIT = B0_SRC;
  localparam int SUM2_BIT = B0_SRC + 1;
  localparam int SC1_BASE = B0_SRC + 2;
  localparam int SC2_BASE = SC1_BASE + SC1_N;
  localparam int ST0_USED = SC2_BASE + SC2_N;

  localparam int TOTAL_SRC = B0_SRC + 2 * BX_SRC;
  localparam int FIQ_IDX_W = 7;
  localparam int FIQ_SPACE = 1 << FIQ_IDX_W;
  localparam int FIQ_PAD   = FIQ_SPACE - TOTAL_SRC;
  localparam int FIQ_CTL_W = FIQ_IDX_W + 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ST0, SEL_ST1, SEL_ST2, SEL_FIQ,
    SEL_SET0, SEL_SET1, SEL_SET2, SEL_CLR0, SEL_CLR1, SEL_CLR2
  } reg_sel_e;

  function automatic reg_sel_e reg_decode(input logic [ADDR_W-1:0] a);
    case (a)
      8'h00:   return SEL_ST0;
      8'h04:   return SEL_ST1;
      8'h08:   return SEL_ST2;
      8'h0C:   return SEL_FIQ;
      8'h10:   return SEL_SET1;
      8'h14:   return SEL_SET2;
      8'h18:   return SEL_SET0;
      8'h1C:   return SEL_CLR1;
      8'h20:   return SEL_CLR2;
      8'h24:   return SEL_CLR0;
      default: return SEL_NONE;
    endcase
  endfunction

  // Source line behind each group 1 shortcut flag, in flag order.
  function automatic int sc1_src(input int k);
    case (k)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      default: return 19;
    endcase
  endfunction

  // Source line behind each group 2 shortcut flag, in flag order.
  function automatic int sc2_src(input int k);
    case (k)
      0:       return 21;
      1:       return 22;
      2:       return 23;
      3:       return 24;
      4:       return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [BX_SRC-1:0] sc1_mask();
    logic [BX_SRC-1:0] m;
    m = '0;
    for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [BX_SRC-1:0] sc2_mask();
    logic [BX_SRC-1:0] m;
    m = '0;
    for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
    return m;
  endfunction

  // Next mask after a set and/or clear strobe.
  function automatic logic [BX_SRC-1:0] mask_next(
      input logic [BX_SRC-1:0] cur, input logic [BX_SRC-1:0] d,
      input logic set_s, input logic clr_s);
    logic [BX_SRC-1:0] n;
    n = cur;
    if (set_s) n = n | d;
    if (clr_s) n = n & ~d;
    return n;
  endfunction

endpackage

// File: rtl/bank_intc_mask.sv
module bank_intc_mask
  import bank_intc_pkg::*;
#(
  parameter int W = BX_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);

  localparam int PAD = BX_SRC - W;

  logic [BX_SRC-1:0] cur_wide;
  logic [BX_SRC-1:0] d_wide;
  logic [BX_SRC-1:0] nxt_wide;

  generate
    if (PAD > 0) begin : g_pad
      assign cur_wide = {{PAD{1'b0}}, en};
      assign d_wide   = {{PAD{1'b0}}, wdata};
    end else begin : g_full
      assign cur_wide = en;
      assign d_wide   = wdata;
    end
  endgenerate

  assign nxt_wide = mask_next(cur_wide, d_wide, set_stb, clr_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= nxt_wide[W-1:0];
  end

endmodule

// File: rtl/bank_intc_status.sv
module bank_intc_status
  import bank_intc_pkg::*;
(
  input  logic [B0_SRC-1:0] src0,
  input  logic [BX_SRC-1:0] src1,
  input  logic [BX_SRC-1:0] src2,
  input  logic [B0_SRC-1:0] en0,
  input  logic [BX_SRC-1:0] en1,
  input  logic [BX_SRC-1:0] en2,
  output logic [WORD_W-1:0] st0,
  output logic [WORD_W-1:0] st1,
  output logic [WORD_W-1:0] st2,
  output logic              sum1,
  output logic              sum2,
  output logic [SC1_N-1:0]  sc1,
  output logic [SC2_N-1:0]  sc2
);

  localparam logic [BX_SRC-1:0] SC1_MASK = sc1_mask();
  localparam logic [BX_SRC-1:0] SC2_MASK = sc2_mask();

  logic [B0_SRC-1:0] pend0;
  logic [BX_SRC-1:0] pend1;
  logic [BX_SRC-1:0] pend2;

  assign pend0 = src0 & en0;
  assign pend1 = src1 & en1;
  assign pend2 = src2 & en2;

  generate
    for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
      assign sc1[k] = pend1[sc1_src(k)];
    end
    for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
      assign sc2[k] = pend2[sc2_src(k)];
    end
  endgenerate

  assign sum1 = |(pend1 & ~SC1_MASK);
  assign sum2 = |(pend2 & ~SC2_MASK);

  always_comb begin
    st0                     = '0;
    st0[B0_SRC-1:0]         = pend0;
    st0[SUM1_BIT]           = sum1;
    st0[SUM2_BIT]           = sum2;
    st0[SC1_BASE +: SC1_N]  = sc1;
    st0[SC2_BASE +: SC2_N]  = sc2;
  end

  assign st1 = pend1;
  assign st2 = pend2;

endmodule

// File: rtl/bank_intc_fiq.sv
module bank_intc_fiq
  import bank_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [FIQ_CTL_W-1:0] wdata,
  input  logic [B0_SRC-1:0]    src0,
  input  logic [BX_SRC-1:0]    src1,
  input  logic [BX_SRC-1:0]    src2,
  output logic [FIQ_CTL_W-1:0] ctl,
  output logic                 sel_hit,
  output logic                 fiq
);

  // Selector order: group 1, group 2, group 0, then dead indices.
  logic [FIQ_SPACE-1:0] raw_space;
  logic [FIQ_IDX_W-1:0] idx;

  assign raw_space = {{FIQ_PAD{1'b0}}, src0, src2, src1};
  assign idx       = ctl[FIQ_IDX_W-1:0];
  assign sel_hit   = raw_space[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_stb) ctl <= wdata;
  end

  assign fiq = ctl[FIQ_IDX_W] & sel_hit;

endmodule

// File: rtl/bank_intc.sv
module bank_intc
  import bank_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [B0_SRC-1:0] src_b0,
  input  logic [BX_SRC-1:0] src_b1,
  input  logic [BX_SRC-1:0] src_b2,
  output logic              irq,
  output logic              fiq
);

  reg_sel_e sel;
  assign sel = reg_decode(addr);

  logic [N_GROUPS-1:0] set_stb;
  logic [N_GROUPS-1:0] clr_stb;
  logic                fiq_wr;

  assign set_stb = {we && sel == SEL_SET2, we && sel == SEL_SET1, we && sel == SEL_SET0};
  assign clr_stb = {we && sel == SEL_CLR2, we && sel == SEL_CLR1, we && sel == SEL_CLR0};
  assign fiq_wr  = we && sel == SEL_FIQ;

  logic [N_GROUPS-1:0][WORD_W-1:0] en_w;

  generate
    for (genvar b = 0; b < N_GROUPS; b++) begin : g_grp
      localparam int GW = (b == 0) ? B0_SRC : BX_SRC;
      bank_intc_mask #(.W(GW)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb[b]),
        .clr_stb (clr_stb[b]),
        .wdata   (wdata[GW-1:0]),
        .en      (en_w[b][GW-1:0])
      );
      if (GW < WORD_W) begin : g_zext
        assign en_w[b][WORD_W-1:GW] = '0;
      end
    end
  endgenerate

  logic [WORD_W-1:0] st0, st1, st2;
  logic              sum1, sum2;
  logic [SC1_N-1:0]  sc1;
  logic [SC2_N-1:0]  sc2;

  bank_intc_status u_status (
    .src0 (src_b0),
    .src1 (src_b1),
    .src2 (src_b2),
    .en0  (en_w[0][B0_SRC-1:0]),
    .en1  (en_w[1][BX_SRC-1:0]),
    .en2  (en_w[2][BX_SRC-1:0]),
    .st0  (st0),
    .st1  (st1),
    .st2  (st2),
    .sum1 (sum1),
    .sum2 (sum2),
    .sc1  (sc1),
    .sc2  (sc2)
  );

  logic [FIQ_CTL_W-1:0] fiq_ctl;
  logic                 fiq_hit;

  bank_intc_fiq u_fiq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (fiq_wr),
    .wdata   (wdata[FIQ_CTL_W-1:0]),
    .src0    (src_b0),
    .src1    (src_b1),
    .src2    (src_b2),
    .ctl     (fiq_ctl),
    .sel_hit (fiq_hit),
    .fiq     (fiq)
  );

  assign irq = |st0[ST0_USED-1:0];

  always_comb begin
    case (sel)
      SEL_ST0:            rdata = st0;
      SEL_ST1:            rdata = st1;
      SEL_ST2:            rdata = st2;
      SEL_FIQ:            rdata = {{(WORD_W-FIQ_CTL_W){1'b0}}, fiq_ctl};
      SEL_SET0, SEL_CLR0: rdata = en_w[0];
      SEL_SET1, SEL_CLR1: rdata = en_w[1];
      SEL_SET2, SEL_CLR2: rdata = en_w[2];
      default:            rdata = '0;
    endcase
  end

endmodule

// File: rtl/bank_intc_chk.sv
module bank_intc_chk
  import bank_intc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input reg_sel_e          sel,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] en1,
  input logic [WORD_W-1:0] st0,
  input logic [WORD_W-1:0] st1,
  input logic [WORD_W-1:0] st2,
  input logic [BX_SRC-1:0] src1,
  input logic [B0_SRC-1:0] src0,
  input logic [BX_SRC-1:0] src2,
  input logic              fiq_en,
  input logic              irq,
  input logic              fiq
);

  assert_set_group1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_SET1) |=> ((en1 & $past(wdata)) == $past(wdata)));

  assert_clr_group1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_CLR1) |=> ((en1 & $past(wdata)) == '0));

  assert_summary_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st0[SUM1_BIT] |-> (src1 != '0));

  assert_shortcut_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st0[SC1_BASE] |-> st1[sc1_src(0)]);

  assert_shortcut_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st0[SC2_BASE + SC2_N - 1] |-> st2[sc2_src(SC2_N - 1)]);

  assert_quiet_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src0 == '0 && src1 == '0 && src2 == '0) |-> !irq);

  assert_fiq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> fiq_en);

endmodule

bind bank_intc bank_intc_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .we     (we),
  .sel    (sel),
  .wdata  (wdata),
  .en1    (en_w[1]),
  .st0    (st0),
  .st1    (st1),
  .st2    (st2),
  .src1   (src_b1),
  .src0   (src_b0),
  .src2   (src_b2),
  .fiq_en (fiq_ctl[7]),
  .irq    (irq),
  .fiq    (fiq)
);

// File: tb/bank_intc_test.sv
`timescale 1ns/1ps
module bank_intc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  src_b0 = '0;
  logic [31:0] src_b1 = '0;
  logic [31:0] src_b2 = '0;
  logic        irq, fiq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bank_intc uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .src_b0(src_b0), .src_b1(src_b1), .src_b2(src_b2),
    .irq(irq), .fiq(fiq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic drive(input logic [7:0] s0, input logic [31:0] s1, input logic [31:0] s2);
    @(negedge clk);
    src_b0 = s0; src_b1 = s1; src_b2 = s2;
    #1;
  endtask

  task automatic clear_all();
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    drive(8'h0, 32'h0, 32'h0);
  endtask

  task automatic t_reset();
    drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_check("R1 mask0", 8'h18, 32'h0);
    rd_check("R1 mask1", 8'h10, 32'h0);
    rd_check("R1 mask2", 8'h14, 32'h0);
    rd_check("R1 fiqctl", 8'h0C, 32'h0);
    rd_check("R1 st0", 8'h00, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 fiq", {31'b0, fiq}, 32'h0);
    drive(8'h0, 32'h0, 32'h0);
  endtask

  task automatic t_mask();
    wr(8'h10, 32'h0000_00F0);
    wr(8'h10, 32'h0000_0F00);
    rd_check("R2 set accumulate", 8'h10, 32'h0000_0FF0);
    wr(8'h1C, 32'h0000_0030);
    rd_check("R2 clear", 8'h10, 32'h0000_0FC0);
    rd_check("R2 clear port readback", 8'h1C, 32'h0000_0FC0);
    wr(8'h14, 32'h8000_0001);
    rd_check("R2 group2 set", 8'h20, 32'h8000_0001);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_check("R7 group0 width", 8'h18, 32'h0000_00FF);
    wr(8'h24, 32'h0000_00FF);
    rd_check("R2 group0 clear", 8'h24, 32'h0);
    clear_all();
  endtask

  task automatic t_level();
    wr(8'h14, 32'hFFFF_FFFF);
    drive(8'h0, 32'h0, 32'h0000_0005);
    rd_check("R3 group2 level", 8'h08, 32'h0000_0005);
    drive(8'h0, 32'h0, 32'h0);
    rd_check("R3 no latch", 8'h08, 32'h0);
    wr(8'h10, 32'h0000_FFFF);
    drive(8'h0, 32'hFFFF_FFFF, 32'h0);
    rd_check("R3 group1 masked", 8'h04, 32'h0000_FFFF);
    wr(8'h18, 32'h0000_000F);
    drive(8'hFF, 32'h0, 32'h0);
    rd_check("R4 group0 status", 8'h00, 32'h0000_000F);
    clear_all();
  endtask

  task automatic t_shortcut();
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    drive(8'h0, 32'h0000_0008, 32'h0);
    rd_check("R5 summary1", 8'h00, 32'h0000_0100);
    drive(8'h0, 32'h0, 32'h0000_0001);
    rd_check("R5 summary2", 8'h00, 32'h0000_0200);
    drive(8'h0, 32'h0000_0080, 32'h0);
    rd_check("R6 line7 st0", 8'h00, 32'h0000_0400);
    rd_check("R6 line7 st1", 8'h04, 32'h0000_0080);
    drive(8'h0, 32'h0008_0000, 32'h0);
    rd_check("R6 line19", 8'h00, 32'h0000_4000);
    drive(8'h0, 32'h0000_0600, 32'h0);
    rd_check("R6 lines9_10", 8'h00, 32'h0000_1800);
    drive(8'h0, 32'h0, 32'h0020_0000);
    rd_check("R6 g2 line21", 8'h00, 32'h0000_8000);
    drive(8'h0, 32'h0, 32'h4000_0000);
    rd_check("R6 g2 line30", 8'h00, 32'h0010_0000);
    drive(8'h0, 32'h0000_0088, 32'h0);
    rd_check("R6 mixed", 8'h00, 32'h0000_0500);
    clear_all();
  endtask

  task automatic t_g0_ignore();
    wr(8'h10, 32'h0000_0080);
    drive(8'h0, 32'h0000_0080, 32'h0);
    wr(8'h1C, 32'h0000_0080);
    rd_check("R7 masked via group1", 8'h00, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h0000_0400);
    rd_check("R7 g0 set ignored st0", 8'h00, 32'h0);
    rd_check("R7 g0 set ignored mask", 8'h18, 32'h0);
    wr(8'h10, 32'h0000_0080);
    wr(8'h24, 32'h0000_0400);
    rd_check("R7 g0 clear ignored", 8'h00, 32'h0000_0400);
    clear_all();
  endtask

  task automatic t_irq();
    wr(8'h18, 32'h0000_0001);
    wr(8'h14, 32'h0000_0004);
    drive(8'h0, 32'h0, 32'h0);
    check("R8 idle", {31'b0, irq}, 32'h0);
    drive(8'h01, 32'h0, 32'h0);
    check("R8 local", {31'b0, irq}, 32'h1);
    drive(8'h0, 32'h0, 32'h0000_0004);
    check("R8 summary", {31'b0, irq}, 32'h1);
    drive(8'h02, 32'hFFFF_FFFF, 32'h0000_0002);
    check("R8 masked", {31'b0, irq}, 32'h0);
    clear_all();
  endtask

  task automatic t_fiq();
    wr(8'h0C, 32'hFFFF_FF85);
    rd_check("R9 readback", 8'h0C, 32'h0000_0085);
    drive(8'h0, 32'h0000_0020, 32'h0);
    check("R9 g1 idx5 fiq", {31'b0, fiq}, 32'h1);
    check("R9 g1 idx5 irq", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h0000_00A3);
    drive(8'h0, 32'h0, 32'h0000_0008);
    check("R9 g2 idx35", {31'b0, fiq}, 32'h1);
    drive(8'h0, 32'h0000_0008, 32'hFFFF_FFF7);
    check("R9 g2 idx35 other", {31'b0, fiq}, 32'h0);
    wr(8'h0C, 32'h0000_00C2);
    drive(8'h04, 32'h0, 32'h0);
    check("R9 g0 idx66", {31'b0, fiq}, 32'h1);
    wr(8'h0C, 32'h0000_00C7);
    drive(8'h80, 32'h0, 32'h0);
    check("R9 g0 idx71", {31'b0, fiq}, 32'h1);
    wr(8'h0C, 32'h0000_00C8);
    drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R9 idx72 dead", {31'b0, fiq}, 32'h0);
    wr(8'h0C, 32'h0000_00FF);
    check("R9 idx127 dead", {31'b0, fiq}, 32'h0);
    wr(8'h0C, 32'h0000_0002);
    check("R9 disabled", {31'b0, fiq}, 32'h0);
    wr(8'h0C, 32'h0000_0085);
    wr(8'h10, 32'h0000_0020);
    drive(8'h0, 32'h0000_0020, 32'h0);
    check("R10 fiq", {31'b0, fiq}, 32'h1);
    check("R10 irq", {31'b0, irq}, 32'h1);
    clear_all();
  endtask

  task automatic t_misc();
    wr(8'h10, 32'h0000_0003);
    drive(8'h0, 32'h0000_0001, 32'h0);
    rd_check("R11 offset28", 8'h28, 32'h0);
    rd_check("R11 misaligned", 8'h02, 32'h0);
    rd_check("R11 offset3C", 8'h3C, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_check("R11 status write mask", 8'h10, 32'h0000_0003);
    rd_check("R11 status write st1", 8'h04, 32'h0000_0001);
    rd_check("R11 status write g0", 8'h18, 32'h0);
    rd_check("R11 status write fiqctl", 8'h0C, 32'h0);
    clear_all();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_level();
    t_shortcut();
    t_g0_ignore();
    t_irq();
    t_fiq();
    t_misc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule